// File: doc/BRIEF.md
# Privileged Exception Entry Sequencer

This block performs the hardware side of taking an exception into privileged firmware. A request arrives with a cause code and, for call-style traps, an 8-bit function code. The block works out the firmware entry offset and adds it to the firmware base register to get the new program counter. It also records the return address, with the current privilege flag folded into bit 0.

If the machine was running in normal mode, the block then exchanges eight architectural integer registers with a private bank of eight shadow registers. It does this one register per cycle through a single register-file port. The read data on that port is combinational, so one cycle both reads and writes the same entry. If the machine was already privileged, no exchange takes place and the entry completes at once.

On completion the block pulses `done_o`. The new PC, the saved address and the enter-privileged indication on its outputs are valid during that pulse. The surrounding core commits them and drops its pending exception. A cause code the block does not know raises `err_o` and commits nothing.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `rf_we_o` are low.
- R2: Cause codes 0 to 9 select fixed offsets equal to the code times 0x80, in this order: reset, machine check, interprocessor interrupt, clock interrupt, device interrupt, memory fault, unaligned access, illegal opcode, arithmetic, FP disabled. `new_pc_o` equals `base_i` plus the offset.
- R3: Cause code 10 is a call trap. When bit 7 of `func_i` is clear, the offset is 0x1000 + func_i × 64.
- R4: For a call trap with bit 7 of `func_i` set, the offset is 0x2000 + (func_i − 0x80) × 64.
- R5: `exc_addr_o` equals `pc_i` ORed with `priv_i` in bit 0, both sampled when the request is accepted.
- R6: An entry with `priv_i` low makes exactly eight register writes. `done_o` is high in the 9th cycle after the accepting edge, and `enter_priv_o` is high with it.
- R7: An entry with `priv_i` high makes no register writes. `done_o` is high in the cycle after the accepting edge, and `enter_priv_o` is low.
- R8: The exchange pairs integer registers 8 through 14 with shadow entries 0 through 6, and register 25 with shadow entry 7. Each pair is a full two-way exchange, so two entries from normal mode restore the original contents. No other register is written. The shadow bank is zero after reset.
- R9: Cause codes 11 to 15 raise `err_o` for one cycle, in the cycle after the accepting edge. They produce no `done_o` and no register write.
- R10: A request presented while `busy_o` is high is ignored. The entry in progress completes with its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Exception request, sampled while idle |
| cause_i | input | 4 | Cause code |
| func_i | input | 8 | Call-trap function code |
| pc_i | input | 64 | Current program counter |
| priv_i | input | 1 | Current privileged-mode flag |
| base_i | input | 64 | Firmware base address |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | One-cycle unknown-cause strobe |
| new_pc_o | output | 64 | Firmware entry address |
| exc_addr_o | output | 64 | Saved return address with mode in bit 0 |
| enter_priv_o | output | 1 | Mode flag must be set on commit |
| rf_addr_o | output | 5 | Register-file index for the exchange |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 64 | Shadow value written to the register file |
| rf_rdata_i | input | 64 | Combinational read data at `rf_addr_o` |

## Verification
A wrong shadow counter or address map shows up on the port within one entry. A register outside the eight is written, or two entries fail to restore the original values, and both are visible after the second `done_o`. A corrupted offset or a stale sampled PC shows on `new_pc_o` or `exc_addr_o` in the same `done_o` cycle. A state machine that takes the wrong path shows as a completion one or nine cycles off its expected position, or as a stray error strobe.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    C_RESET = 4'd0, C_MCHK = 4'd1, C_IPI = 4'd2, C_CLK = 4'd3, C_DEV = 4'd4,
    C_MMF = 4'd5, C_UNAL = 4'd6, C_OPC = 4'd7, C_ARITH = 4'd8, C_FEN = 4'd9,
    C_CALL = 4'd10
  } cause_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SWAP, ST_FIN} state_e;

  localparam int unsigned BANK_LO  = 8;   // first architectural register exchanged
  localparam int unsigned BANK_TOP = 25;  // last bank entry maps here
endpackage

// File: rtl/exc_entry_offset.sv
module exc_entry_offset #(
  parameter int unsigned FUNC_W = 8,
  parameter int unsigned OFS_W  = 14
) (
  input  logic [exc_entry_pkg::CAUSE_W-1:0] cause_i,
  input  logic [FUNC_W-1:0]                 func_i,
  output logic [OFS_W-1:0]                  offset_o,
  output logic                              valid_o
);
  import exc_entry_pkg::*;

  localparam int unsigned FIXED_SH = 7;
  localparam int unsigned SLOT_SH  = 6;
  localparam logic [OFS_W-1:0] PRIV_BASE = OFS_W'(14'h1000);
  localparam logic [OFS_W-1:0] USER_BASE = OFS_W'(14'h2000);

  logic [OFS_W-1:0] slot;
  assign slot = OFS_W'(func_i[FUNC_W-2:0]) << SLOT_SH;

  always_comb begin
    valid_o  = 1'b1;
    offset_o = '0;
    if (cause_i <= C_FEN)        offset_o = OFS_W'(cause_i) << FIXED_SH;
    else if (cause_i == C_CALL)  offset_o = (func_i[FUNC_W-1] ? USER_BASE : PRIV_BASE) + slot;
    else                         valid_o  = 1'b0;
  end
endmodule

// File: rtl/exc_shadow_swap.sv
module exc_shadow_swap #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic [AW-1:0]   rf_addr_o,
  output logic            rf_we_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            last_o
);
  import exc_entry_pkg::*;

  localparam int unsigned CW = (NREG > 1) ? $clog2(NREG) : 1;

  logic            active_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] shadow_q [NREG];

  assign last_o     = active_q && (cnt_q == CW'(NREG - 1));
  assign rf_we_o    = active_q;
  assign rf_wdata_o = shadow_q[cnt_q];
  assign rf_addr_o  = (cnt_q == CW'(NREG - 1)) ? AW'(BANK_TOP) : AW'(BANK_LO) + AW'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      active_q <= !last_o;
      cnt_q    <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                shadow_q[i] <= '0;
      else if (active_q && cnt_q == CW'(i))       shadow_q[i] <= rf_rdata_i;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned AW     = 5,
  parameter int unsigned FUNC_W = 8,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned NREG   = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_i,
  input  logic [exc_entry_pkg::CAUSE_W-1:0]  cause_i,
  input  logic [FUNC_W-1:0]                  func_i,
  input  logic [XLEN-1:0]                    pc_i,
  input  logic                               priv_i,
  input  logic [XLEN-1:0]                    base_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic                               err_o,
  output logic [XLEN-1:0]                    new_pc_o,
  output logic [XLEN-1:0]                    exc_addr_o,
  output logic                               enter_priv_o,
  output logic [AW-1:0]                      rf_addr_o,
  output logic                               rf_we_o,
  output logic [XLEN-1:0]                    rf_wdata_o,
  input  logic [XLEN-1:0]                    rf_rdata_i
);
  import exc_entry_pkg::*;

  state_e           state_q;
  logic [OFS_W-1:0] offset;
  logic             ofs_valid, accept, swap_start, swap_last;
  logic             err_q, enter_q;
  logic [XLEN-1:0]  new_pc_q, exc_addr_q;

  exc_entry_offset #(.FUNC_W(FUNC_W), .OFS_W(OFS_W)) u_ofs (
    .cause_i(cause_i), .func_i(func_i), .offset_o(offset), .valid_o(ofs_valid)
  );

  exc_shadow_swap #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_swap (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(swap_start), .rf_rdata_i(rf_rdata_i),
    .rf_addr_o(rf_addr_o), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .last_o(swap_last)
  );

  assign accept     = (state_q == ST_IDLE) && req_i;
  assign swap_start = accept && ofs_valid && !priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_q      <= 1'b0;
      enter_q    <= 1'b0;
      new_pc_q   <= '0;
      exc_addr_q <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (ofs_valid) begin
            new_pc_q   <= base_i + XLEN'(offset);
            exc_addr_q <= pc_i | XLEN'(priv_i);
            enter_q    <= !priv_i;
            state_q    <= priv_i ? ST_FIN : ST_SWAP;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_SWAP: if (swap_last) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = err_q;
  assign new_pc_o     = new_pc_q;
  assign exc_addr_o   = exc_addr_q;
  assign enter_priv_o = enter_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic            enter_priv_o,
  input logic [AW-1:0]   rf_addr_o,
  input logic            rf_we_o
);
  assert_done_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_err_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && $past(req_i)));
  assert_write_normal_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (busy_o && enter_priv_o && !done_o));
  assert_swap_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ((rf_addr_o >= AW'(8) && rf_addr_o <= AW'(14)) || rf_addr_o == AW'(25)));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_target_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(new_pc_o));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .new_pc_o(new_pc_o), .enter_priv_o(enter_priv_o),
  .rf_addr_o(rf_addr_o), .rf_we_o(rf_we_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk_i = 0, rst_ni = 0, req_i = 0, priv_i = 0;
  logic [3:0]  cause_i = 0;
  logic [7:0]  func_i = 0;
  logic [63:0] pc_i = 0, base_i = 0;
  logic        busy_o, done_o, err_o, enter_priv_o, rf_we_o;
  logic [63:0] new_pc_o, exc_addr_o, rf_wdata_o, rf_rdata_i;
  logic [4:0]  rf_addr_o;

  logic [63:0] rf [32];
  int n_chk = 0, n_bad = 0, n_wr = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  exc_entry_seq u0 (.*);

  assign rf_rdata_i = rf[rf_addr_o];
  always @(posedge clk_i) if (rf_we_o) begin rf[rf_addr_o] <= rf_wdata_o; n_wr++; end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [63:0] exp_ofs(input int c, input int f);
    if (c <= 9) return 64'(c * 128);
    if (f >= 128) return 64'(8192 + (f - 128) * 64);
    return 64'(4096 + f * 64);
  endfunction

  function automatic logic [63:0] init_val(input int i);
    return 64'hA5A5_0000_0000_0000 + 64'(i * 1000 + 7);
  endfunction

  // Returns cycles from accepting edge until done or err seen (sampled on negedges)
  task automatic run_entry(input int c, input int f, input logic [63:0] pc, input logic [63:0] base,
                           input bit pr, output int cyc, output bit saw_err, output bit saw_done);
    @(negedge clk_i);
    req_i = 1; cause_i = 4'(c); func_i = 8'(f); pc_i = pc; base_i = base; priv_i = pr;
    @(negedge clk_i);
    req_i = 0; pc_i = 64'hDEAD_BEEF_0000_0000; base_i = 0; priv_i = ~pr;
    cyc = 1;
    while (!done_o && !err_o && cyc < 20) begin @(negedge clk_i); cyc++; end
    saw_err = err_o; saw_done = done_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc, w0;
    bit se, sd;
    logic [63:0] pc, base;
    for (int i = 0; i < 32; i++) rf[i] = init_val(i);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !done_o && !err_o && !rf_we_o, "R1 reset outputs", {busy_o, done_o, err_o, rf_we_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !err_o, "R1 idle after reset", {busy_o, done_o, err_o}, 0);

    // R2/R5/R7/R9 sweep all cause codes from privileged mode
    for (int c = 0; c < 16; c++) begin
      pc = 64'h0000_1234_5678_0000 + 64'(c * 4);
      base = 64'h0000_0040_0000_0000 + 64'(c) * 64'h1_0000;
      w0 = n_wr;
      run_entry(c, 5, pc, base, 1'b1, cyc, se, sd);
      if (c <= 10) begin
        check(sd && cyc == 1, "R7 done timing privileged", 64'(cyc), 1);
        check(new_pc_o == base + exp_ofs(c, 5), "R2 new pc", new_pc_o, base + exp_ofs(c, 5));
        check(exc_addr_o == (pc | 64'd1), "R5 saved address", exc_addr_o, pc | 64'd1);
        check(!enter_priv_o, "R7 no mode change", 64'(enter_priv_o), 0);
      end else begin
        check(se && !sd && cyc == 1, "R9 error strobe", {se, sd}, 2);
        @(negedge clk_i);
        check(!err_o && !done_o && !busy_o, "R9 error single cycle", {err_o, done_o, busy_o}, 0);
      end
      check(n_wr == w0, "R7 R9 no register writes", 64'(n_wr - w0), 0);
    end

    // R3/R4 sweep all function codes
    for (int f = 0; f < 256; f++) begin
      base = 64'hFFFF_0000_0010_0000;
      run_entry(10, f, 64'h8000 + 64'(f * 4), base, 1'b1, cyc, se, sd);
      if (f < 128) check(sd && new_pc_o == base + exp_ofs(10, f), "R3 call trap low", new_pc_o, base + exp_ofs(10, f));
      else         check(sd && new_pc_o == base + exp_ofs(10, f), "R4 call trap high", new_pc_o, base + exp_ofs(10, f));
    end

    // R6/R8 first entry from normal mode: shadow zero goes in
    pc = 64'h0000_0000_0012_3450;
    w0 = n_wr;
    run_entry(3, 0, pc, 64'h9000_0000, 1'b0, cyc, se, sd);
    check(sd && cyc == 9, "R6 done after eight swaps", 64'(cyc), 9);
    check(enter_priv_o, "R6 enter privileged", 64'(enter_priv_o), 1);
    check(n_wr - w0 == 8, "R6 eight writes", 64'(n_wr - w0), 8);
    check(exc_addr_o == pc, "R5 saved address normal", exc_addr_o, pc);
    check(new_pc_o == 64'h9000_0180, "R2 clock entry", new_pc_o, 64'h9000_0180);
    for (int i = 0; i < 32; i++) begin
      if ((i >= 8 && i <= 14) || i == 25) check(rf[i] == 0, "R8 bank reg got shadow", rf[i], 0);
      else check(rf[i] == init_val(i), "R8 other reg untouched", rf[i], init_val(i));
    end

    // R10 second normal entry with a stray request injected while busy
    @(negedge clk_i);
    req_i = 1; cause_i = 4'd8; func_i = 0; pc_i = 64'h4000; base_i = 64'h7000_0000; priv_i = 0;
    @(negedge clk_i);
    req_i = 0; cyc = 1; se = 0;
    @(negedge clk_i); cyc++;
    req_i = 1; cause_i = 4'd12; base_i = 64'h1;
    @(negedge clk_i); cyc++;
    req_i = 1; cause_i = 4'd1; priv_i = 1;
    @(negedge clk_i); cyc++;
    req_i = 0;
    while (!done_o && cyc < 20) begin se |= err_o; @(negedge clk_i); cyc++; end
    check(!se && done_o && cyc == 9, "R10 stray request ignored", 64'(cyc), 9);
    check(new_pc_o == 64'h7000_0400, "R10 target kept", new_pc_o, 64'h7000_0400);
    for (int i = 0; i < 32; i++)
      check(rf[i] == init_val(i), "R8 two-way exchange restores", rf[i], init_val(i));
    @(negedge clk_i);
    check(!busy_o && !done_o && !err_o, "R10 idle after entry", {busy_o, done_o, err_o}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule